// File: doc/BRIEF.md
# Convolution weight traversal sequencer

This block produces, one beat at a time, the order in which an accelerator consumes the weights of one brick of a convolution weight tensor held in height, width, input-channel, output-channel order. Each beat carries either the source coordinate to read (absolute kernel row, absolute kernel column, input channel, output channel) or a flag telling the consumer to insert a zero.

A controller loads the brick geometry and the traversal mode with a single start pulse. The sequencer then walks a fixed nest of ten loops. The shape of that nest depends on the mode. Large kernels are cut into subkernels. Element counts are padded up to the multiple the datapath needs. Any coordinate that falls outside the brick becomes a zero beat. Beats leave on a valid/ready stream, and a one-cycle done pulse closes the walk. Mode selection, weight compression and memory access belong to other blocks.

Top module: `wtWalkSeq`

## Requirements
- R1: During and straight after reset, `outValid` and `outDone` are low.
- R2: A `start` pulse while idle samples all configuration inputs, and `outValid` is high on the following cycle. A `start` during a walk is ignored, and the walk continues unchanged.
- R3: `cfgMode` encodes 0 = depth-first, 1 = part-kernel-first, 2 = depthwise. Beats follow this nest, from outermost to innermost: output block (step `cfgOutBlk`), input block, subkernel row, subkernel column, outer input micro-block (part-kernel-first only), output micro-block, kernel element, inner input micro-block (depth-first only), output lane (0..OFM_UBLK-1), input lane (0..IFM_UBLK-1).
- R4: The input block depth is 16 in part-kernel-first mode or when `cfgWide16` is 1. Otherwise it is 32.
- R5: The kernel is split into subkernels of at most SUB_MAX_H rows by SUB_MAX_W columns. The last subkernel in each direction keeps only the remaining rows or columns.
- R6: In part-kernel-first mode the element count of a subkernel (rows times columns) rounds up to a multiple of 2 when `cfgWide16`=1, and to a multiple of 4 otherwise. In depthwise mode it always rounds up to a multiple of 4. In depth-first mode it is not rounded.
- R7: Element index e gives local column e mod subkernel width and local row e div subkernel width. `outKy`/`outKx` are the subkernel origin plus these.
- R8: `outZero`=1 exactly when the input channel is at least `cfgInDepth`, the output channel is at least `cfgOutDepth`, or the local row is at least the subkernel height.
- R9: Depthwise mode runs one input block iteration, uses IFM_UBLK as the input block depth and one input lane per element.
- R10: The output block is clipped to the remaining output depth. The input block is clipped to the remaining input depth only in part-kernel-first mode. Depth-first always uses the full block depth.
- R11: While `outValid` is high and `outReady` is low, the beat stays valid and all beat fields hold their values.
- R12: `outDone` pulses for one cycle, in the cycle after the last beat is accepted, with `outValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk with the current configuration |
| cfgKernH | input | KER_W | Kernel height, at least 1 |
| cfgKernW | input | KER_W | Kernel width, at least 1 |
| cfgInDepth | input | DIM_W | Input channel count, at least 1 |
| cfgOutDepth | input | DIM_W | Output channel count, at least 1 |
| cfgOutBlk | input | DIM_W | Output block depth, at least 1 |
| cfgWide16 | input | 1 | 1 for 16-bit input, 0 for 8-bit |
| cfgMode | input | 2 | Traversal mode (see R3) |
| outValid | output | 1 | Beat valid |
| outReady | input | 1 | Consumer accepts the beat |
| outZero | output | 1 | Insert a zero rather than read |
| outKy | output | KER_W+1 | Absolute kernel row |
| outKx | output | KER_W+1 | Absolute kernel column |
| outIc | output | DIM_W+1 | Input channel |
| outOc | output | DIM_W+1 | Output channel |
| outDone | output | 1 | End-of-walk pulse |

## Verification
The bench goes after the corner cases where the nest is easiest to get wrong. It uses output depths that leave a short last output block, input depths that are not a multiple of the block depth in both depth-first and part-kernel-first modes, and kernels taller or wider than the subkernel limit, so that one subkernel is a single row or column. It also covers odd element counts in both input widths. If a design clipped the input block in depth-first mode, mis-rounded the element count, or took kx and ky from the full kernel width, the beat count would shift or a coordinate or zero flag would differ, and the beat-by-beat comparison against the bench's own loop nest would show it. Random back-pressure exercises the hold rule, and a start pulse sent partway through a walk shows whether the configuration is wrongly reloaded.

// File: rtl/wtWalkPkg.sv
package wtWalkPkg;

  typedef enum logic [1:0] {
    MODE_DEPTH = 2'd0,
    MODE_PARTK = 2'd1,
    MODE_DWISE = 2'd2
  } travMode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

endpackage

// File: rtl/wtWalkCtrl.sv
module wtWalkCtrl
  import wtWalkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       outReady,
  input  logic       lastBeat,
  output logic       outValid,
  output logic       outDone,
  output seqStrobe_t strb
);

  seqState_e state;

  assign outValid    = (state == ST_RUN);
  assign strb.load    = (state == ST_IDLE) && start;
  assign strb.advance = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      outDone <= 1'b0;
    end else begin
      outDone <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN: begin
          if (outReady && lastBeat) begin
            state   <= ST_IDLE;
            outDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // The done pulse only appears once the stream is idle.
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> !outValid);

  // A walk only begins because of a start pulse.
  assert_valid_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(start));

endmodule

// File: rtl/wtWalkPath.sv
module wtWalkPath
  import wtWalkPkg::*;
#(
  parameter int KER_W     = 4,
  parameter int DIM_W     = 8,
  parameter int IFM_UBLK  = 8,
  parameter int OFM_UBLK  = 8,
  parameter int SUB_MAX_H = 8,
  parameter int SUB_MAX_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic [KER_W-1:0]    cfgKernH,
  input  logic [KER_W-1:0]    cfgKernW,
  input  logic [DIM_W-1:0]    cfgInDepth,
  input  logic [DIM_W-1:0]    cfgOutDepth,
  input  logic [DIM_W-1:0]    cfgOutBlk,
  input  logic                cfgWide16,
  input  logic [1:0]          cfgMode,
  output logic                outZero,
  output logic [KER_W:0]      outKy,
  output logic [KER_W:0]      outKx,
  output logic [DIM_W:0]      outIc,
  output logic [DIM_W:0]      outOc,
  output logic                lastBeat
);

  localparam int CH_W   = DIM_W + 1;
  localparam int KC_W   = KER_W + 1;
  localparam int EL_W   = $clog2(SUB_MAX_H * SUB_MAX_W + 4) + 1;
  localparam int LEVELS = 10;

  localparam logic [CH_W-1:0] IU    = CH_W'(IFM_UBLK);
  localparam logic [CH_W-1:0] OU    = CH_W'(OFM_UBLK);
  localparam logic [KC_W-1:0] SMH   = KC_W'(SUB_MAX_H);
  localparam logic [KC_W-1:0] SMW   = KC_W'(SUB_MAX_W);

  // sampled configuration
  logic [KC_W-1:0] kh, kw;
  logic [CH_W-1:0] inD, outD, blk;
  logic            wide;
  travMode_e       mode;

  // loop counters, innermost first
  logic [CH_W-1:0] il, ol, iui, ou, iuo, ibz, obz;
  logic [EL_W-1:0] el;
  logic [KC_W-1:0] sx, sy, kx, ky;

  logic isPk, isDw;
  logic [CH_W-1:0] ifmBlk, remOut, remIn, clipOfm, clipIfm, outerDepth, innerDepth, ilLast;
  logic [KC_W-1:0] remH, remW, subH, subW;
  logic [EL_W-1:0] rawEl, elems;
  logic [LEVELS-1:0] lastV;
  logic [LEVELS:0]   carry;

  always_comb begin
    isPk    = (mode == MODE_PARTK);
    isDw    = (mode == MODE_DWISE);
    ifmBlk  = (isPk || wide) ? CH_W'(16) : CH_W'(32);
    remOut  = outD - obz;
    clipOfm = (blk < remOut) ? blk : remOut;
    remIn   = inD - ibz;
    if (isDw)      clipIfm = IU;
    else if (isPk) clipIfm = (ifmBlk < remIn) ? ifmBlk : remIn;
    else           clipIfm = ifmBlk;
    outerDepth = isPk ? clipIfm : CH_W'(1);
    innerDepth = isPk ? CH_W'(1) : clipIfm;
    ilLast     = isDw ? '0 : IU - CH_W'(1);

    remH = kh - sy;
    remW = kw - sx;
    subH = (remH > SMH) ? SMH : remH;
    subW = (remW > SMW) ? SMW : remW;
    rawEl = EL_W'(subH) * EL_W'(subW);
    if (isDw || (isPk && !wide)) elems = (rawEl + EL_W'(3)) & ~EL_W'(3);
    else if (isPk)               elems = (rawEl + EL_W'(1)) & ~EL_W'(1);
    else                         elems = rawEl;
  end

  always_comb begin
    lastV[0] = (il == ilLast);
    lastV[1] = (ol == OU - CH_W'(1));
    lastV[2] = (iui + IU >= innerDepth);
    lastV[3] = (el == elems - EL_W'(1));
    lastV[4] = (ou + OU >= clipOfm);
    lastV[5] = (iuo + IU >= outerDepth);
    lastV[6] = (sx + SMW >= kw);
    lastV[7] = (sy + SMH >= kh);
    lastV[8] = isDw || (ibz + ifmBlk >= inD);
    lastV[9] = (obz + blk >= outD);
    carry[0] = strb.advance;
    for (int i = 0; i < LEVELS; i++) carry[i+1] = carry[i] & lastV[i];
  end

  assign lastBeat = &lastV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kh <= '0; kw <= '0; inD <= '0; outD <= '0; blk <= '0;
      wide <= 1'b0; mode <= MODE_DEPTH;
      il <= '0; ol <= '0; iui <= '0; ou <= '0; iuo <= '0; ibz <= '0; obz <= '0;
      el <= '0; sx <= '0; sy <= '0; kx <= '0; ky <= '0;
    end else if (strb.load) begin
      kh   <= KC_W'(cfgKernH);
      kw   <= KC_W'(cfgKernW);
      inD  <= CH_W'(cfgInDepth);
      outD <= CH_W'(cfgOutDepth);
      blk  <= CH_W'(cfgOutBlk);
      wide <= cfgWide16;
      mode <= travMode_e'(cfgMode);
      il <= '0; ol <= '0; iui <= '0; ou <= '0; iuo <= '0; ibz <= '0; obz <= '0;
      el <= '0; sx <= '0; sy <= '0; kx <= '0; ky <= '0;
    end else begin
      if (carry[0]) il  <= lastV[0] ? '0 : il + CH_W'(1);
      if (carry[1]) ol  <= lastV[1] ? '0 : ol + CH_W'(1);
      if (carry[2]) iui <= lastV[2] ? '0 : iui + IU;
      if (carry[3]) begin
        if (lastV[3]) begin
          el <= '0; kx <= '0; ky <= '0;
        end else begin
          el <= el + EL_W'(1);
          if (kx == subW - KC_W'(1)) begin
            kx <= '0;
            ky <= ky + KC_W'(1);
          end else begin
            kx <= kx + KC_W'(1);
          end
        end
      end
      if (carry[4]) ou  <= lastV[4] ? '0 : ou + OU;
      if (carry[5]) iuo <= lastV[5] ? '0 : iuo + IU;
      if (carry[6]) sx  <= lastV[6] ? '0 : sx + SMW;
      if (carry[7]) sy  <= lastV[7] ? '0 : sy + SMH;
      if (carry[8]) ibz <= lastV[8] ? '0 : ibz + ifmBlk;
      if (carry[9]) obz <= lastV[9] ? '0 : obz + blk;
    end
  end

  always_comb begin
    outIc   = ibz + iuo + iui + il;
    outOc   = obz + ou + ol;
    outKy   = sy + ky;
    outKx   = sx + kx;
    outZero = (outIc >= inD) || (outOc >= outD) || (ky >= subH);
  end

  // The column counter and the element counter move together, so the column stays inside the subkernel.
  assert_kx_in_sub_R7: assert property (@(posedge clk) disable iff (!rstN)
    (subW != '0) |-> (kx < subW));

  // The element index never passes the padded count of the current subkernel.
  assert_el_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (elems != '0) |-> (el < elems));

endmodule

// File: rtl/wtWalkSeq.sv
module wtWalkSeq
  import wtWalkPkg::*;
#(
  parameter int KER_W     = 4,
  parameter int DIM_W     = 8,
  parameter int IFM_UBLK  = 8,
  parameter int OFM_UBLK  = 8,
  parameter int SUB_MAX_H = 8,
  parameter int SUB_MAX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [KER_W-1:0] cfgKernH,
  input  logic [KER_W-1:0] cfgKernW,
  input  logic [DIM_W-1:0] cfgInDepth,
  input  logic [DIM_W-1:0] cfgOutDepth,
  input  logic [DIM_W-1:0] cfgOutBlk,
  input  logic             cfgWide16,
  input  logic [1:0]       cfgMode,
  output logic             outValid,
  input  logic             outReady,
  output logic             outZero,
  output logic [KER_W:0]   outKy,
  output logic [KER_W:0]   outKx,
  output logic [DIM_W:0]   outIc,
  output logic [DIM_W:0]   outOc,
  output logic             outDone
);

  seqStrobe_t strb;
  logic       lastBeat;

  wtWalkCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .outReady(outReady),
    .lastBeat(lastBeat), .outValid(outValid), .outDone(outDone), .strb(strb)
  );

  wtWalkPath #(
    .KER_W(KER_W), .DIM_W(DIM_W), .IFM_UBLK(IFM_UBLK), .OFM_UBLK(OFM_UBLK),
    .SUB_MAX_H(SUB_MAX_H), .SUB_MAX_W(SUB_MAX_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgKernH(cfgKernH), .cfgKernW(cfgKernW), .cfgInDepth(cfgInDepth),
    .cfgOutDepth(cfgOutDepth), .cfgOutBlk(cfgOutBlk), .cfgWide16(cfgWide16),
    .cfgMode(cfgMode), .outZero(outZero), .outKy(outKy), .outKx(outKx),
    .outIc(outIc), .outOc(outOc), .lastBeat(lastBeat)
  );

  // A stalled beat stays offered and unchanged.
  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable({outZero, outKy, outKx, outIc, outOc})));

endmodule

// File: tb/sim_wtWalkSeq.sv
`timescale 1ns/1ps
module sim_wtWalkSeq;

  localparam int KER_W = 4, DIM_W = 8, IU = 8, OU = 8, SH = 8, SW = 8;

  typedef struct packed {
    logic           z;
    logic [KER_W:0] ky;
    logic [KER_W:0] kx;
    logic [DIM_W:0] ic;
    logic [DIM_W:0] oc;
  } beat_t;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, outReady = 1'b0;
  logic [KER_W-1:0] cfgKernH = '0, cfgKernW = '0;
  logic [DIM_W-1:0] cfgInDepth = '0, cfgOutDepth = '0, cfgOutBlk = '0;
  logic cfgWide16 = 1'b0;
  logic [1:0] cfgMode = '0;
  logic outValid, outZero, outDone;
  logic [KER_W:0] outKy, outKx;
  logic [DIM_W:0] outIc, outOc;

  int checks = 0, fails = 0;
  beat_t expQ[$];
  string curTag = "R1";
  logic doneSeen = 1'b0;
  logic running = 1'b0;
  logic prevStall = 1'b0;
  beat_t prevBeat;

  always #2 clk = ~clk;

  wtWalkSeq #(.KER_W(KER_W), .DIM_W(DIM_W), .IFM_UBLK(IU), .OFM_UBLK(OU),
              .SUB_MAX_H(SH), .SUB_MAX_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgKernH(cfgKernH), .cfgKernW(cfgKernW),
    .cfgInDepth(cfgInDepth), .cfgOutDepth(cfgOutDepth), .cfgOutBlk(cfgOutBlk),
    .cfgWide16(cfgWide16), .cfgMode(cfgMode), .outValid(outValid), .outReady(outReady),
    .outZero(outZero), .outKy(outKy), .outKx(outKx), .outIc(outIc), .outOc(outOc),
    .outDone(outDone)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(logic ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected order built straight from the requirement text (R3..R10).
  task automatic buildRef(int mode, int wide, int kh, int kw, int inD, int outD, int blk);
    int ifmBlk;
    ifmBlk = (mode == 1 || wide != 0) ? 16 : 32;
    for (int obz = 0; obz < outD; obz += blk) begin
      int cOfm;
      cOfm = imin(blk, outD - obz);
      for (int ibz = 0; ibz < ((mode == 2) ? 1 : inD); ibz += ifmBlk) begin
        int cIfm;
        cIfm = (mode == 2) ? IU : ((mode == 1) ? imin(ifmBlk, inD - ibz) : ifmBlk);
        for (int sy = 0; sy < kh; sy += SH) begin
          for (int sx = 0; sx < kw; sx += SW) begin
            int sh, sw, n, outerD, innerD;
            sh = imin(kh - sy, SH);
            sw = imin(kw - sx, SW);
            n = sh * sw;
            if (mode == 1) n = (wide != 0) ? ((n + 1) / 2) * 2 : ((n + 3) / 4) * 4;
            else if (mode == 2) n = ((n + 3) / 4) * 4;
            outerD = (mode == 1) ? cIfm : 1;
            innerD = (mode == 1) ? 1 : cIfm;
            for (int iuo = 0; iuo < outerD; iuo += IU)
              for (int ou = 0; ou < cOfm; ou += OU)
                for (int e = 0; e < n; e++)
                  for (int iui = 0; iui < innerD; iui += IU)
                    for (int ol = 0; ol < OU; ol++)
                      for (int il = 0; il < ((mode == 2) ? 1 : IU); il++) begin
                        beat_t b;
                        int ic, oc, kx, ky;
                        kx = e % sw;
                        ky = e / sw;
                        ic = ibz + iuo + iui + il;
                        oc = obz + ou + ol;
                        b.z  = (ic >= inD) || (oc >= outD) || (ky >= sh);
                        b.ky = (KER_W+1)'(sy + ky);
                        b.kx = (KER_W+1)'(sx + kx);
                        b.ic = (DIM_W+1)'(ic);
                        b.oc = (DIM_W+1)'(oc);
                        expQ.push_back(b);
                      end
          end
        end
      end
    end
  endtask

  // ready driver: random back-pressure, changed just after each rising edge
  always @(posedge clk) begin
    #1 outReady <= ($urandom_range(0, 3) != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      beat_t cur;
      cur = '{z: outZero, ky: outKy, kx: outKx, ic: outIc, oc: outOc};
      if (prevStall)
        check(outValid && (cur == prevBeat), {curTag, " R11 hold"}, 64'(cur), 64'(prevBeat));
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, {curTag, " extra beat"}, 64'(cur), 64'd0);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          check(cur == e, {curTag, " beat"}, 64'(cur), 64'(e));
        end
      end
      if (outDone) begin
        doneSeen = 1'b1;
        check(!outValid && expQ.size() == 0, "R12 done after last beat",
              64'({outValid, 16'(expQ.size())}), 64'd0);
      end
      prevStall = outValid && !outReady;
      prevBeat  = cur;
    end
  end

  task automatic runCase(string tag, int mode, int wide, int kh, int kw, int inD, int outD,
                         int blk, bit midStart);
    curTag = tag;
    expQ.delete();
    buildRef(mode, wide, kh, kw, inD, outD, blk);
    @(negedge clk);
    check(!outValid, "R2 idle before start", 64'(outValid), 64'd0);
    cfgMode = 2'(mode); cfgWide16 = wide[0];
    cfgKernH = KER_W'(kh); cfgKernW = KER_W'(kw);
    cfgInDepth = DIM_W'(inD); cfgOutDepth = DIM_W'(outD); cfgOutBlk = DIM_W'(blk);
    doneSeen = 1'b0; prevStall = 1'b0; running = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(outValid, "R2 valid after start", 64'(outValid), 64'd1);
    if (midStart) begin
      repeat (20) @(negedge clk);
      // R2: a second start with a different configuration must not disturb the walk
      cfgMode = 2'd0; cfgKernH = 4'd1; cfgKernW = 4'd1; cfgOutDepth = 8'd1; cfgOutBlk = 8'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!doneSeen) @(negedge clk);
    @(negedge clk);
    check(!outDone, "R12 done is one cycle", 64'(outDone), 64'd0);
    running = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !outDone, "R1 reset state", 64'({outValid, outDone}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !outDone, "R1 after reset", 64'({outValid, outDone}), 64'd0);
    // depth-first 8-bit, short last output block, full 32-deep input block: R3 R4 R8 R10
    runCase("R3 R4 R10 depth-first", 0, 0, 3, 3, 5, 10, 8, 1'b0);
    // depth-first 16-bit, tall kernel split into 8+2 rows, two input blocks: R4 R5 R7
    runCase("R5 R7 depth-first split", 0, 1, 10, 2, 20, 8, 8, 1'b0);
    // part-kernel-first 8-bit, input block clipped to 4, 9 elements padded to 12: R6 R10 R8
    runCase("R6 R10 part-kernel 8b", 1, 0, 3, 3, 20, 12, 16, 1'b0);
    // part-kernel-first 16-bit, wide kernel split 8+1 columns, 3 elements padded to 4: R5 R6 R7 R8
    runCase("R6 R8 part-kernel 16b", 1, 1, 3, 9, 8, 8, 8, 1'b0);
    // depthwise, 9 elements padded to 12, with a start during the walk: R9 R2
    runCase("R9 R2 depthwise", 2, 0, 3, 3, 1, 16, 8, 1'b1);
    // depthwise 16-bit, 9x1 kernel split 8+1 rows, single output block clipped to 5: R9 R5 R10
    runCase("R9 R5 depthwise split", 2, 1, 9, 1, 1, 5, 16, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule